// File: doc/BRIEF.md
# Two-Point ADC Gain and Offset Corrector

This block straightens the transfer line of an N-bit converter. Software or a neighbouring controller first converts two known reference levels, one at a quarter and one at three quarters of full scale, and hands the two raw results to the block on separate strobed inputs. A calibrate command then makes the block derive a fixed-point gain, scaled by one million, and a signed offset. It does this with a shared sequential divider.

In normal operation every raw sample on the input stream goes through the line `raw * gain / 1e6 + offset`. The result is clamped to the converter's code range and leaves one cycle later on the output stream. If the high reading is not above the low reading, the block raises an error flag and keeps its old coefficients. While the coefficients are being computed, the input stream is held off. After reset the line is the identity.

Top module: `adc_twopoint_cal`

## Requirements
- R1: After reset the gain is 1,000,000 and the offset is 0, so every sample leaves unchanged; `cal_err` is 0, `cal_busy` is 0 and `s_ready` is 1.
- R2: A successful calibration sets gain = floor((2^N/2) * 1,000,000 / (hi - lo)), where lo and hi are the latched reference readings (targets 2^N/4 and 3*2^N/4).
- R3: A successful calibration sets offset = 2^N/4 - floor(lo * gain / 1,000,000), a signed value that may be negative.
- R4: A sample accepted on a clock edge (`s_valid` and `s_ready` high) appears on `m_data` with `m_valid` high after the next edge, with value floor(raw * gain / 1,000,000) + offset.
- R5: If `cal_start` arrives while hi <= lo, `cal_err` is 1 after that edge, `cal_busy` stays 0, and gain and offset keep their previous values.
- R6: A `cal_start` with hi > lo clears `cal_err` on that edge.
- R7: From the edge after an accepted `cal_start` until the new coefficients are installed, `cal_busy` is 1 and `s_ready` is 0, and no sample is accepted or produced.
- R8: `ref_lo_valid`, `ref_hi_valid` and `cal_start` have no effect while `cal_busy` is 1.
- R9: Each reference reading is latched on its strobe and held. A later `cal_start` without new strobes reuses the held readings and gives the same coefficients.
- R10: A corrected value below 0 leaves as 0, and one above 2^N-1 leaves as 2^N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Start calibration from the latched readings |
| ref_lo_valid | input | 1 | Strobe for the quarter-scale reading |
| ref_lo_data | input | RAW_W | Raw reading of the quarter-scale reference |
| ref_hi_valid | input | 1 | Strobe for the three-quarter-scale reading |
| ref_hi_data | input | RAW_W | Raw reading of the three-quarter-scale reference |
| s_valid | input | 1 | Raw sample valid |
| s_data | input | RAW_W | Raw sample |
| s_ready | output | 1 | Block accepts a raw sample |
| m_valid | output | 1 | Corrected sample valid |
| m_data | output | RAW_W | Corrected, clamped sample |
| cal_busy | output | 1 | Coefficients being computed |
| cal_err | output | 1 | Last calibration attempt had hi <= lo |

## Verification
The assertions assume that `cal_start` and the reference strobes are single-cycle pulses from a synchronous source. They also assume that no divide is ever launched with a zero divisor, which the block ensures by refusing calibrations with hi <= lo. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It drives samples only when `s_ready` is high, except in the directed case that deliberately pushes samples and strobes into a running calibration to show that they are refused.

// File: rtl/adc_cal_pkg.sv
// Shared constants and types for the two-point ADC corrector.
// Assumes coefficients and intermediate products fit in 64 bits (N <= 16).
package adc_cal_pkg;
    localparam int          COEF_W = 64;
    localparam longint      SCALE  = 64'd1000000;

    typedef logic [COEF_W-1:0]        coef_t;
    typedef logic signed [COEF_W-1:0] soff_t;

    typedef enum logic [1:0] {
        CAL_IDLE,
        CAL_GAIN,
        CAL_OFS
    } cal_state_e;
endpackage

// File: rtl/cal_divider.sv
// Sequential restoring divider: one quotient bit per cycle, MSB first.
// Assumes start only while idle and a nonzero divisor; operands unsigned.
// done pulses for one cycle with the quotient held until the next start.
module cal_divider #(
    parameter int DIV_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [DIV_W-1:0] quotient
);
    localparam int CNT_W = $clog2(DIV_W + 1);

    logic [DIV_W-1:0] rem_q, quo_q, dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q;
    logic [DIV_W:0]   shifted;
    logic             fits;

    // Shift in the next dividend bit and test whether the divisor fits.
    always_comb begin
        shifted = {rem_q, quo_q[DIV_W-1]};
        fits    = (shifted >= {1'b0, dvs_q});
    end

    // Iteration control, partial remainder and quotient shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start && !busy_q) begin
            rem_q  <= '0;
            quo_q  <= dividend;
            dvs_q  <= divisor;
            cnt_q  <= CNT_W'(DIV_W - 1);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            rem_q  <= fits ? DIV_W'(shifted - {1'b0, dvs_q}) : shifted[DIV_W-1:0];
            quo_q  <= {quo_q[DIV_W-2:0], fits};
            cnt_q  <= cnt_q - 1'b1;
            busy_q <= (cnt_q != '0);
            done_q <= (cnt_q == '0);
        end else begin
            done_q <= 1'b0;
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign quotient = quo_q;

    // R7: a new division never interrupts one in flight.
    p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    // R2: the divisor handed over is never zero.
    p_div_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (divisor != '0));
    // R7: done follows the end of an iteration run.
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q));
endmodule

// File: rtl/cal_sequencer.sv
// Calibration sequencer: latches the two reference readings, checks their
// order, runs gain then offset divisions on the shared divider and installs
// both coefficients together. Assumes single-cycle command and strobes.
module cal_sequencer
    import adc_cal_pkg::*;
#(
    parameter int RAW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_start,
    input  logic             ref_lo_valid,
    input  logic [RAW_W-1:0] ref_lo_data,
    input  logic             ref_hi_valid,
    input  logic [RAW_W-1:0] ref_hi_data,
    output logic             busy,
    output logic             err,
    output coef_t            gain,
    output soff_t            offset
);
    localparam coef_t NOM_LO  = coef_t'(1) << (RAW_W - 2);
    localparam coef_t HALF_FS = coef_t'(1) << (RAW_W - 1);
    localparam coef_t GAIN_NUM = HALF_FS * coef_t'(SCALE);

    cal_state_e       state_q;
    logic [RAW_W-1:0] lo_q, hi_q;
    logic             err_q;
    coef_t            gain_q, gain_new_q;
    soff_t            ofs_q;
    logic             accept, order_ok;
    logic             div_start, div_busy, div_done;
    coef_t            div_num, div_den, div_q;

    assign accept   = cal_start && (state_q == CAL_IDLE);
    assign order_ok = (hi_q > lo_q);

    // Pick the divider operands for the step being launched.
    always_comb begin
        div_start = 1'b0;
        div_num   = GAIN_NUM;
        div_den   = coef_t'(hi_q - lo_q);
        if (accept && order_ok) begin
            div_start = 1'b1;
        end else if (state_q == CAL_GAIN && div_done) begin
            div_start = 1'b1;
            div_num   = coef_t'(lo_q) * div_q;
            div_den   = coef_t'(SCALE);
        end
    end

    cal_divider #(.DIV_W(COEF_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_num),
        .divisor  (div_den),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_q)
    );

    // Latch reference readings while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (state_q == CAL_IDLE) begin
            if (ref_lo_valid) lo_q <= ref_lo_data;
            if (ref_hi_valid) hi_q <= ref_hi_data;
        end
    end

    // Step through gain and offset divisions, then install coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CAL_IDLE;
            err_q      <= 1'b0;
            gain_q     <= coef_t'(SCALE);
            gain_new_q <= '0;
            ofs_q      <= '0;
        end else begin
            case (state_q)
                CAL_IDLE: if (accept) begin
                    err_q <= !order_ok;
                    if (order_ok) state_q <= CAL_GAIN;
                end
                CAL_GAIN: if (div_done) begin
                    gain_new_q <= div_q;
                    state_q    <= CAL_OFS;
                end
                CAL_OFS: if (div_done) begin
                    gain_q  <= gain_new_q;
                    ofs_q   <= $signed(NOM_LO) - $signed(div_q);
                    state_q <= CAL_IDLE;
                end
                default: state_q <= CAL_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != CAL_IDLE);
    assign err    = err_q;
    assign gain   = gain_q;
    assign offset = ofs_q;

    // R5 / R8: coefficients only move at the end of a running calibration.
    p_coef_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_IDLE) |=> ($stable(gain_q) && $stable(ofs_q)));
    // R5: a refused calibration never raises busy.
    p_err_nobusy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (state_q == CAL_IDLE));
    // R8: held readings do not change during a calibration.
    p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CAL_IDLE) |=> ($stable(lo_q) && $stable(hi_q)));
    // R2: the divider is active whenever the sequencer waits on it.
    p_wait_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != CAL_IDLE) && !div_done) |-> div_busy);
    // R2: an installed gain is never zero.
    p_gain_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q != '0);
endmodule

// File: rtl/sample_mapper.sv
// Maps one raw sample per cycle through raw*gain/1e6 + offset and clamps to
// the N-bit code range; one register stage. Assumes the product fits 64 bits.
module sample_mapper
    import adc_cal_pkg::*;
#(
    parameter int RAW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fire,
    input  logic [RAW_W-1:0] in_data,
    input  coef_t            gain,
    input  soff_t            offset,
    output logic             out_valid,
    output logic [RAW_W-1:0] out_data
);
    localparam soff_t CODE_MAX = soff_t'((64'd1 << RAW_W) - 64'd1);

    coef_t            scaled;
    soff_t            sum;
    logic [RAW_W-1:0] clamped;

    // Scale, add offset and saturate to the converter range.
    always_comb begin
        scaled = (coef_t'(in_data) * gain) / coef_t'(SCALE);
        sum    = $signed(scaled) + offset;
        if (sum < 0)             clamped = '0;
        else if (sum > CODE_MAX) clamped = '1;
        else                     clamped = RAW_W'(sum);
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_fire;
            if (in_fire) out_data <= clamped;
        end
    end

    // R4: each output follows exactly one accepted input.
    p_one_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> out_valid);
endmodule

// File: rtl/adc_twopoint_cal.sv
// Two-point ADC corrector top: sequencer computes gain/offset from two
// reference readings, mapper corrects the sample stream. Input stream is
// held off while coefficients are being computed.
module adc_twopoint_cal
    import adc_cal_pkg::*;
#(
    parameter int RAW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_start,
    input  logic             ref_lo_valid,
    input  logic [RAW_W-1:0] ref_lo_data,
    input  logic             ref_hi_valid,
    input  logic [RAW_W-1:0] ref_hi_data,
    input  logic             s_valid,
    input  logic [RAW_W-1:0] s_data,
    output logic             s_ready,
    output logic             m_valid,
    output logic [RAW_W-1:0] m_data,
    output logic             cal_busy,
    output logic             cal_err
);
    coef_t gain;
    soff_t offset;
    logic  busy;

    initial begin
        if (RAW_W != 10 && RAW_W != 12)
            $error("RAW_W must be 10 or 12");
    end

    cal_sequencer #(.RAW_W(RAW_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_start    (cal_start),
        .ref_lo_valid (ref_lo_valid),
        .ref_lo_data  (ref_lo_data),
        .ref_hi_valid (ref_hi_valid),
        .ref_hi_data  (ref_hi_data),
        .busy         (busy),
        .err          (cal_err),
        .gain         (gain),
        .offset       (offset)
    );

    assign s_ready  = !busy;
    assign cal_busy = busy;

    sample_mapper #(.RAW_W(RAW_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_fire   (s_valid && !busy),
        .in_data   (s_data),
        .gain      (gain),
        .offset    (offset),
        .out_valid (m_valid),
        .out_data  (m_data)
    );

    // R7: an output only follows a sample offered while not busy.
    p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ($past(s_valid) && !$past(cal_busy)));
    // R7: busy is entered only from an accepted command.
    p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy) |-> $past(cal_start));
endmodule

// File: tb/test_adc_twopoint_cal.sv
`timescale 1ns/1ps
module test_adc_twopoint_cal;
    localparam int  N    = 12;
    localparam int  NV   = 8;
    localparam longint MAXC = (64'd1 << N) - 1;

    // Table: lo reading, hi reading, raw sample.
    localparam logic [N-1:0] T_LO [NV] = '{12'd1000, 12'd1000, 12'd1000, 12'd1500,
                                           12'd1500, 12'd1500, 12'd1024, 12'd0};
    localparam logic [N-1:0] T_HI [NV] = '{12'd3100, 12'd3100, 12'd3100, 12'd2500,
                                           12'd2500, 12'd2500, 12'd3072, 12'd4095};
    localparam logic [N-1:0] T_RAW[NV] = '{12'd0, 12'd4095, 12'd2048, 12'd0,
                                           12'd4095, 12'd2000, 12'd777, 12'd4095};

    logic clk = 0, rst_n = 0;
    logic cal_start = 0, ref_lo_valid = 0, ref_hi_valid = 0, s_valid = 0;
    logic [N-1:0] ref_lo_data = '0, ref_hi_data = '0, s_data = '0;
    logic s_ready, m_valid, cal_busy, cal_err;
    logic [N-1:0] m_data;

    int total = 0, bad = 0, cycles = 0;
    longint g_m = 1000000, o_m = 0;

    always #4 clk = ~clk;

    adc_twopoint_cal #(.RAW_W(N)) i_adc_twopoint_cal (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .ref_lo_valid(ref_lo_valid), .ref_lo_data(ref_lo_data),
        .ref_hi_valid(ref_hi_valid), .ref_hi_data(ref_hi_data),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .m_valid(m_valid), .m_data(m_data),
        .cal_busy(cal_busy), .cal_err(cal_err));

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint model_out(input longint raw);
        longint v = (raw * g_m) / 1000000 + o_m;
        if (v < 0) v = 0;
        if (v > MAXC) v = MAXC;
        return v;
    endfunction

    // R2/R3 model update for a successful calibration.
    task automatic model_cal(input longint lo, input longint hi);
        g_m = ((64'd1 << (N - 1)) * 1000000) / (hi - lo);
        o_m = (64'd1 << (N - 2)) - (lo * g_m) / 1000000;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && cal_busy; k++) @(negedge clk);
    endtask

    // Send one sample, check it one edge later (R4).
    task automatic send(input string tag, input logic [N-1:0] raw);
        @(negedge clk);
        s_valid = 1; s_data = raw;
        @(negedge clk);
        s_valid = 0;
        check({tag, " m_valid"}, m_valid, 1);
        check({tag, " m_data"}, m_data, model_out(raw));
    endtask

    task automatic strobe_refs(input logic [N-1:0] lo, input logic [N-1:0] hi);
        @(negedge clk); ref_lo_valid = 1; ref_lo_data = lo;
        @(negedge clk); ref_lo_valid = 0; ref_hi_valid = 1; ref_hi_data = hi;
        @(negedge clk); ref_hi_valid = 0;
    endtask

    task automatic kick(input bit ok);
        @(negedge clk); cal_start = 1;
        @(negedge clk); cal_start = 0;
        check("R7 busy after start", cal_busy, ok);
        check("R5/R6 err after start", cal_err, !ok);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [N-1:0] cur_lo, cur_hi;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state and identity pass-through.
        check("R1 err", cal_err, 0);
        check("R1 busy", cal_busy, 0);
        check("R1 ready", s_ready, 1);
        check("R1 m_valid", m_valid, 0);
        send("R1 pass", 12'd1234);
        send("R1 pass max", 12'd4095);

        // Table walk: R2, R3, R4, R10.
        cur_lo = '0; cur_hi = '0;
        for (int i = 0; i < NV; i++) begin
            if (i == 0 || T_LO[i] != cur_lo || T_HI[i] != cur_hi) begin
                cur_lo = T_LO[i]; cur_hi = T_HI[i];
                strobe_refs(cur_lo, cur_hi);
                kick(1);
                wait_idle();
                model_cal(cur_lo, cur_hi);
            end
            send($sformatf("R2/R3/R4/R10 vec%0d", i), T_RAW[i]);
        end

        // R10: explicit clamp with negative offset.
        strobe_refs(12'd1500, 12'd2500);
        kick(1); wait_idle(); model_cal(1500, 2500);
        send("R10 clamp low", 12'd100);
        check("R10 low is zero", m_data, 0);
        send("R10 clamp high", 12'd3900);
        check("R10 high is max", m_data, MAXC);

        // R5: equal and reversed readings refused, coefficients kept.
        strobe_refs(12'd2000, 12'd2000);
        kick(0);
        send("R5 kept after equal", 12'd2000);
        strobe_refs(12'd3000, 12'd1000);
        kick(0);
        send("R5 kept after reversed", 12'd2100);

        // R6: successful start clears the error.
        strobe_refs(12'd900, 12'd3000);
        kick(1);
        check("R6 err cleared", cal_err, 0);

        // R7/R8: samples, strobes and start pushed into a running calibration.
        s_valid = 1; s_data = 12'd500;
        ref_lo_valid = 1; ref_lo_data = 12'd10; cal_start = 1;
        @(negedge clk);
        check("R7 ready low", s_ready, 0);
        check("R7 no output", m_valid, 0);
        ref_lo_valid = 0; cal_start = 0;
        @(negedge clk);
        check("R7 still no output", m_valid, 0);
        s_valid = 0;
        wait_idle();
        model_cal(900, 3000);
        @(negedge clk);
        check("R7 no late output", m_valid, 0);
        send("R8 strobe ignored", 12'd1234);

        // R9: restart without new strobes reuses held readings.
        kick(1); wait_idle();
        send("R9 held readings", 12'd3333);
        send("R9 held readings low", 12'd50);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule